// File: doc/BRIEF.md
# Virtual-Channel Output Port Allocator with Credit Flow Control

This block manages one output port of a wormhole router that has virtual channels. Several input virtual channels offer flits to the port. Each flit has a kind: head, body, tail, or a single flit that both opens and closes a packet. A head flit needs three things before it can leave: a free downstream virtual channel, a free downstream buffer slot on that channel, and the link for one cycle. Body and tail flits keep using the virtual channel their head won, so they only need a buffer slot and the link. When a tail is sent, its virtual channel becomes free again.

Each downstream virtual channel has a credit counter. The counter starts at the downstream buffer depth. It goes down by one for each flit sent on that channel, and up by one for each credit-return pulse from the downstream router. Free virtual channels are handed out by a round-robin pointer. The link is shared among all eligible inputs by a second round-robin arbiter. Because of this, a packet that has run out of credits does not stop other packets from using the link. Route computation and the crossbar datapath belong to neighbouring blocks.

The grant to an input is combinational, in the same cycle as its request. The granted flit appears on the registered output one cycle later, tagged with its downstream virtual channel.

Top module: `vc_out_alloc`

## Requirements
- R1: After synchronous reset, `out_valid` is low, no grant is given without a request, every virtual channel is free, and every credit counter holds `CRED_DEPTH`.
- R2: A head flit (kind 2'b10) from an input that holds no virtual channel is granted only while some virtual channel is both free and has nonzero credit. It takes the first such channel found by a round-robin search that starts after the last channel handed out; the first allocation after reset gets channel 0.
- R3: A body (2'b00) or tail (2'b01) flit is granted only when its input holds a virtual channel whose credit count is nonzero. It is sent on that same channel.
- R4: Sending a flit on a channel lowers that channel's credit count by one, and a `credit_ret` pulse raises it by one. Both in the same cycle leave the count unchanged. A channel with zero credits sends nothing until a credit returns.
- R5: Sending a tail flit frees the input's virtual channel so that another head can be given it.
- R6: A single-flit packet (2'b11) allocates a channel and releases it in the same cycle, so the channel stays free afterwards.
- R7: At most one input is granted per cycle. Eligible inputs are served round-robin, starting after the last input granted.
- R8: An input whose channel has no credit does not stop another eligible input from being granted.
- R9: A body or tail flit from an input that holds no virtual channel is ignored: no grant and no output flit.
- R10: A flit granted in cycle t appears in cycle t+1 on `out_valid`, `out_vc`, `out_kind` and `out_data`. `out_valid` is low in a cycle that follows no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | Per-input flit offered |
| in_kind | input | NUM_IN x 2 | Per-input flit kind (00 body, 01 tail, 10 head, 11 single) |
| in_data | input | NUM_IN x DATA_W | Per-input flit payload |
| in_grant | output | NUM_IN | Per-input flit accepted this cycle |
| credit_ret | input | NUM_VC | Per-channel credit-return pulse from downstream |
| out_valid | output | 1 | Flit on the link |
| out_vc | output | clog2(NUM_VC) | Downstream virtual channel of the flit |
| out_kind | output | 2 | Kind of the flit |
| out_data | output | DATA_W | Payload of the flit |

## Verification
The bench builds the block with five inputs, four virtual channels, a credit depth of four and a 16-bit payload. Having five inputs and only four channels means a fifth head can find every channel owned, so the bench can show that a tail's release lets that head through. A depth of four lets a channel run out of credit after a head and three bodies. From that state the bench checks a lone credit return, a send and a return in the same cycle, and a stalled input sitting beside one that keeps moving.

// File: rtl/vc_alloc_pkg.sv
`timescale 1ns/1ps
package vc_alloc_pkg;

    typedef enum logic [1:0] {
        KIND_BODY   = 2'b00,
        KIND_TAIL   = 2'b01,
        KIND_HEAD   = 2'b10,
        KIND_SINGLE = 2'b11
    } flit_kind_e;

    function automatic logic kind_opens(input logic [1:0] k);
        return k[1];
    endfunction

    function automatic logic kind_closes(input logic [1:0] k);
        return k[0];
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vco_rr_pick.sv
`timescale 1ns/1ps
module vco_rr_pick #(
    parameter int N = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [N-1:0]                         req,
    input  logic                                 advance,
    output logic [N-1:0]                         gnt,
    output logic                                 any,
    output logic [vc_alloc_pkg::idx_width(N)-1:0] gnt_idx
);
    localparam int IDX_W = vc_alloc_pkg::idx_width(N);

    logic [IDX_W-1:0] last_q;

    function automatic int slot(input int base, input int k);
        return (base + 1 + k) % N;
    endfunction

    always_comb begin
        gnt     = '0;
        any     = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!any && req[slot(int'(last_q), k)]) begin
                any                         = 1'b1;
                gnt[slot(int'(last_q), k)] = 1'b1;
                gnt_idx                     = IDX_W'(slot(int'(last_q), k));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDX_W'(N - 1);
        end else if (advance && any) begin
            last_q <= gnt_idx;
        end
    end

    p_pick_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~req) == '0));

endmodule

// File: rtl/vco_credit_ctr.sv
`timescale 1ns/1ps
module vco_credit_ctr #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic avail
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= CNT_W'(DEPTH);
        end else begin
            case ({take, give})
                2'b10:   count_q <= count_q - 1'b1;
                2'b01:   count_q <= count_q + 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign avail = (count_q != '0);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        !(give && !take && count_q == CNT_W'(DEPTH)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        take |-> count_q != '0);

endmodule

// File: rtl/vc_out_alloc.sv
`timescale 1ns/1ps
module vc_out_alloc
    import vc_alloc_pkg::*;
#(
    parameter int NUM_IN     = 4,
    parameter int NUM_VC     = 4,
    parameter int CRED_DEPTH = 4,
    parameter int DATA_W     = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [NUM_IN-1:0]                      in_valid,
    input  logic [NUM_IN-1:0][1:0]                 in_kind,
    input  logic [NUM_IN-1:0][DATA_W-1:0]          in_data,
    output logic [NUM_IN-1:0]                      in_grant,
    input  logic [NUM_VC-1:0]                      credit_ret,
    output logic                                   out_valid,
    output logic [vc_alloc_pkg::idx_width(NUM_VC)-1:0] out_vc,
    output logic [1:0]                             out_kind,
    output logic [DATA_W-1:0]                      out_data
);
    localparam int VC_W = idx_width(NUM_VC);
    localparam int IN_W = idx_width(NUM_IN);

    // per-input ownership of a downstream channel
    logic [NUM_IN-1:0]            own_valid;
    logic [NUM_IN-1:0][VC_W-1:0]  own_vc;
    logic [NUM_VC-1:0]            vc_busy;

    logic [NUM_VC-1:0]            credit_ok;
    logic [NUM_VC-1:0]            cred_take;

    logic [NUM_VC-1:0]            pick_gnt;
    logic                         pick_any;
    logic [VC_W-1:0]              pick_idx;

    logic [NUM_IN-1:0]            eligible;
    logic                         link_any;
    logic [IN_W-1:0]              win_idx;
    logic [1:0]                   win_kind;
    logic                         win_opens;
    logic                         win_closes;
    logic [VC_W-1:0]              send_vc;

    // free-channel chooser
    vco_rr_pick #(.N(NUM_VC)) u_vc_pick (
        .clk     (clk),
        .rst     (rst),
        .req     (~vc_busy & credit_ok),
        .advance (link_any && win_opens),
        .gnt     (pick_gnt),
        .any     (pick_any),
        .gnt_idx (pick_idx)
    );

    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            if (kind_opens(in_kind[i])) begin
                eligible[i] = in_valid[i] && !own_valid[i] && pick_any;
            end else begin
                eligible[i] = in_valid[i] && own_valid[i] && credit_ok[own_vc[i]];
            end
        end
    end

    // link arbiter
    vco_rr_pick #(.N(NUM_IN)) u_link_pick (
        .clk     (clk),
        .rst     (rst),
        .req     (eligible),
        .advance (1'b1),
        .gnt     (in_grant),
        .any     (link_any),
        .gnt_idx (win_idx)
    );

    assign win_kind   = in_kind[win_idx];
    assign win_opens  = kind_opens(win_kind);
    assign win_closes = kind_closes(win_kind);
    assign send_vc    = win_opens ? pick_idx : own_vc[win_idx];

    // credit counters, one per downstream channel
    for (genvar v = 0; v < NUM_VC; v++) begin : g_credit
        assign cred_take[v] = link_any && (send_vc == VC_W'(v));
        vco_credit_ctr #(.DEPTH(CRED_DEPTH)) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .take  (cred_take[v]),
            .give  (credit_ret[v]),
            .avail (credit_ok[v])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_valid <= '0;
            own_vc    <= '0;
            vc_busy   <= '0;
            out_valid <= 1'b0;
            out_vc    <= '0;
            out_kind  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= link_any;
            out_vc    <= send_vc;
            out_kind  <= win_kind;
            out_data  <= in_data[win_idx];
            if (link_any) begin
                if (win_opens && !win_closes) begin
                    own_valid[win_idx] <= 1'b1;
                    own_vc[win_idx]    <= pick_idx;
                    vc_busy            <= vc_busy | pick_gnt;
                end else if (!win_opens && win_closes) begin
                    own_valid[win_idx]        <= 1'b0;
                    vc_busy[own_vc[win_idx]]  <= 1'b0;
                end
            end
        end
    end

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_grant));

    p_out_follows_r10: assert property (@(posedge clk) disable iff (rst)
        (|in_grant) |=> out_valid);

    p_out_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !(|in_grant) |=> !out_valid);

    p_head_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == KIND_HEAD) |-> vc_busy[out_vc]);

    p_body_on_owned_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == KIND_BODY) |-> vc_busy[out_vc]);

    p_close_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind[0]) |-> !vc_busy[out_vc]);

endmodule

// File: tb/test_vc_out_alloc.sv
`timescale 1ns/1ps
module test_vc_out_alloc;
    localparam int NI = 5;
    localparam int NV = 4;
    localparam int DW = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NI-1:0]      in_valid = '0;
    logic [NI-1:0][1:0] in_kind = '0;
    logic [NI-1:0][DW-1:0] in_data = '0;
    logic [NI-1:0]      in_grant;
    logic [NV-1:0]      credit_ret = '0;
    logic               out_valid;
    logic [1:0]         out_vc;
    logic [1:0]         out_kind;
    logic [DW-1:0]      out_data;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vc_out_alloc #(.NUM_IN(NI), .NUM_VC(NV), .CRED_DEPTH(4), .DATA_W(DW)) i_vc_out_alloc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_data(in_data),
        .in_grant(in_grant), .credit_ret(credit_ret), .out_valid(out_valid),
        .out_vc(out_vc), .out_kind(out_kind), .out_data(out_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        in_valid   = '0;
        credit_ret = '0;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic send(input string tag, input int i, input logic [1:0] k,
                        input logic [DW-1:0] d, input bit go, input int vc);
        in_valid[i] = 1'b1;
        in_kind[i]  = k;
        in_data[i]  = d;
        #1;
        chk({tag, " grant"}, 32'(in_grant[i]), 32'(go));
        tick();
        chk({tag, " out_valid"}, 32'(out_valid), 32'(go));
        if (go) begin
            chk({tag, " out_vc"}, 32'(out_vc), 32'(vc));
            chk({tag, " out_kind"}, 32'(out_kind), 32'(k));
            chk({tag, " out_data"}, 32'(out_data), 32'(d));
        end
        in_valid = '0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 out_valid after reset", 32'(out_valid), 0);
        chk("R1 no grant after reset", 32'(in_grant), 0);
    endtask

    task automatic t_single();
        do_reset();
        send("R6 single in2", 2, 2'b11, 16'hA1, 1, 0);
        send("R6 single in3", 3, 2'b11, 16'hA2, 1, 1);
        send("R2 single in0", 0, 2'b11, 16'hA3, 1, 2);
        send("R2 single in1", 1, 2'b11, 16'hA4, 1, 3);
        send("R6 reuse vc0", 4, 2'b11, 16'hA5, 1, 0);
        send("R6 reuse vc1", 2, 2'b11, 16'hA6, 1, 1);
    endtask

    task automatic t_credit();
        do_reset();
        send("R2 head in1", 1, 2'b10, 16'h0100, 1, 0);
        for (int b = 0; b < 3; b++)
            send("R3 body same vc", 1, 2'b00, 16'h0101 + 16'(b), 1, 0);
        send("R4 body no credit", 1, 2'b00, 16'h0110, 0, 0);
        credit_ret[0] = 1'b1;
        tick();
        credit_ret = '0;
        in_valid[1] = 1'b1; in_kind[1] = 2'b00; in_data[1] = 16'h0111;
        credit_ret[0] = 1'b1;
        #1;
        chk("R4 send with return grant", 32'(in_grant[1]), 1);
        tick();
        credit_ret = '0;
        in_valid = '0;
        chk("R4 send with return out_vc", 32'(out_vc), 0);
        send("R4 count held at one", 1, 2'b00, 16'h0112, 1, 0);
        send("R4 count now zero", 1, 2'b00, 16'h0113, 0, 0);
    endtask

    task automatic t_release();
        do_reset();
        for (int i = 0; i < 4; i++)
            send("R2 head takes vc", i, 2'b10, 16'(16'h0200 + i), 1, i);
        send("R2 head no free vc", 4, 2'b10, 16'h0204, 0, 0);
        send("R5 tail in0", 0, 2'b01, 16'h0205, 1, 0);
        send("R5 head after release", 4, 2'b10, 16'h0206, 1, 0);
    endtask

    task automatic t_link_rr();
        do_reset();
        send("R7 head in0", 0, 2'b10, 16'h0300, 1, 0);
        send("R7 head in1", 1, 2'b10, 16'h0301, 1, 1);
        in_valid[0] = 1'b1; in_kind[0] = 2'b00; in_data[0] = 16'h0310;
        in_valid[1] = 1'b1; in_kind[1] = 2'b00; in_data[1] = 16'h0311;
        for (int c = 0; c < 4; c++) begin
            #1;
            chk("R7 alternating grant", 32'(in_grant), (c % 2 == 0) ? 32'h1 : 32'h2);
            tick();
            chk("R7 alternating vc", 32'(out_vc), (c % 2 == 0) ? 0 : 1);
        end
        in_valid = '0;
    endtask

    task automatic t_isolation();
        do_reset();
        send("R8 head in0", 0, 2'b10, 16'h0400, 1, 0);
        for (int b = 0; b < 3; b++)
            send("R8 fill vc0", 0, 2'b00, 16'(16'h0401 + b), 1, 0);
        in_valid[0] = 1'b1; in_kind[0] = 2'b00; in_data[0] = 16'h0410;
        in_valid[1] = 1'b1; in_kind[1] = 2'b10; in_data[1] = 16'h0420;
        #1;
        chk("R8 head passes stalled", 32'(in_grant), 32'h2);
        tick();
        chk("R8 head vc", 32'(out_vc), 1);
        in_kind[1] = 2'b00; in_data[1] = 16'h0421;
        #1;
        chk("R8 body passes stalled", 32'(in_grant), 32'h2);
        tick();
        chk("R8 body data", 32'(out_data), 32'h0421);
        in_valid = '0;
    endtask

    task automatic t_orphan();
        do_reset();
        send("R9 body without vc", 2, 2'b00, 16'h0500, 0, 0);
        send("R9 tail without vc", 3, 2'b01, 16'h0501, 0, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_credit();
        t_release();
        t_link_rr();
        t_isolation();
        t_orphan();
        finish_run();
    end

endmodule